// File: doc/BRIEF.md
# Dual-Enable Static RAM Model

This block is a synthesizable, clocked behavioural model of a byte-wide asynchronous static RAM. It serves as a memory target in simulation. Two select inputs of opposite polarity, a read-request input and a write-request input are decoded into four modes: sleep (deselected), idle (selected with the outputs off), read and write. Instead of a three-state bus, the model has a separate data input, a data output and a drive-enable flag. A standby flag shows when the part is deselected.

The array depth is set by `ADDR_W`. With `ADDR_W = 16` the array holds the full 65,536 words of 8 bits. The default is smaller so that elaboration stays light. A write happens at each rising clock edge during which the part is selected and the write request is active, using the address and input data present at that edge. The read word, the drive-enable flag and the standby flag are all registered. They appear one clock edge after the inputs that cause them.

Top module: `sram_dual_en`

## Requirements
- R1: While `rst_n` is low, `dout_en` is 0, `dout` is 0 and `standby` is 1.
- R2: The part is selected only when `en_low_n` is 0 and `en_high` is 1 at a rising edge. In every other case, after that edge `standby` is 1 and `dout_en` is 0.
- R3: When the part is selected with `wr_req_n` at 0, the mode is write whatever `out_req_n` is, and after that edge `dout_en` is 0 and `standby` is 0.
- R4: The array stores `din` at `addr` only at an edge where the part is selected and `wr_req_n` is 0. If `en_low_n` is 1, `en_high` is 0 or `wr_req_n` is 1 at an edge, the stored contents do not change.
- R5: When the part is selected with `wr_req_n` at 1 and `out_req_n` at 0, after that edge `dout_en` is 1 and `dout` holds the word stored at `addr`. This includes a word written at the immediately preceding edge.
- R6: When the part is selected with both `wr_req_n` and `out_req_n` at 1, after that edge `dout_en` is 0 and `standby` is 0.
- R7: `dout` is 0 whenever `dout_en` is 0.
- R8: Stored words are kept through any number of deselected, idle or read cycles, and through writes to other addresses.
- R9: Writes at back-to-back edges to different addresses each store their own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; the rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset of the output flags |
| en_low_n | input | 1 | Select input, active low |
| en_high | input | 1 | Select input, active high |
| out_req_n | input | 1 | Read output request, active low |
| wr_req_n | input | 1 | Write request, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not driving |
| dout_en | output | 1 | High when the model would drive the data pins |
| standby | output | 1 | High while deselected |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The standby and drive flags reflect the mode decoded at that edge. The read word reflects the array contents before that edge. A write therefore becomes visible through a read issued at the next edge, and its data appears one edge after that. The bench changes inputs on the falling edge and checks the outputs on the following falling edge against a reference array that it updates only after computing the expected read. This keeps the expected values aligned with the single register stage and with the read-before-write order inside one edge.

// File: rtl/sram_dual_pkg.sv
package sram_dual_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_t;

  // Selection needs both enables; write wins over the read request.
  function automatic sram_mode_t decode_mode(input logic lo_n, input logic hi,
                                             input logic oreq_n, input logic wreq_n);
    if (lo_n || !hi) return MODE_SLEEP;
    if (!wreq_n)     return MODE_WRITE;
    if (!oreq_n)     return MODE_READ;
    return MODE_IDLE;
  endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_dual_pkg::*;
(
  input  logic       rst_n,
  input  logic       en_low_n,
  input  logic       en_high,
  input  logic       out_req_n,
  input  logic       wr_req_n,
  output sram_mode_t mode,
  output logic       wr_strobe,
  output logic       rd_strobe,
  output logic       asleep
);

  always_comb begin
    mode      = decode_mode(en_low_n, en_high, out_req_n, wr_req_n);
    wr_strobe = rst_n && (mode == MODE_WRITE);
    rd_strobe = (mode == MODE_READ);
    asleep    = (mode == MODE_SLEEP);
  end

endmodule

// File: rtl/sram_word_store.sv
module sram_word_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read returns the contents before this edge's write.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic              asleep,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              standby
);

  logic drive_q;
  logic stby_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      stby_q  <= 1'b1;
    end else begin
      drive_q <= rd_strobe;
      stby_q  <= asleep;
    end
  end

  assign dout_en = drive_q;
  assign standby = stby_q;
  assign dout    = drive_q ? rdata : '0;

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  p_sleep_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !dout_en);

endmodule

// File: rtl/sram_dual_en.sv
module sram_dual_en
  import sram_dual_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_low_n,
  input  logic              en_high,
  input  logic              out_req_n,
  input  logic              wr_req_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              standby
);

  sram_mode_t        mode;
  logic              wr_strobe;
  logic              rd_strobe;
  logic              asleep;
  logic [DATA_W-1:0] rdata;

  sram_mode_decode u_decode (
    .rst_n     (rst_n),
    .en_low_n  (en_low_n),
    .en_high   (en_high),
    .out_req_n (out_req_n),
    .wr_req_n  (wr_req_n),
    .mode      (mode),
    .wr_strobe (wr_strobe),
    .rd_strobe (rd_strobe),
    .asleep    (asleep)
  );

  sram_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_strobe),
    .addr  (addr),
    .wdata (din),
    .rdata (rdata)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .asleep    (asleep),
    .rdata     (rdata),
    .dout      (dout),
    .dout_en   (dout_en),
    .standby   (standby)
  );

  p_deselect_sleeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_low_n || !en_high) |=> (standby && !dout_en));

  p_write_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_low_n && en_high && !wr_req_n) |=> (!dout_en && !standby));

  p_read_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_low_n && en_high && wr_req_n && !out_req_n) |=> dout_en);

  p_outputs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_low_n && en_high && wr_req_n && out_req_n) |=> (!dout_en && !standby));

  p_write_only_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (mode == MODE_WRITE) && !asleep);

endmodule

// File: tb/sram_dual_en_bench.sv
module sram_dual_en_bench;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_low_n = 1'b1;
  logic          en_high = 1'b0;
  logic          out_req_n = 1'b1;
  logic          wr_req_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          standby;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  sram_dual_en #(.ADDR_W(AW), .DATA_W(DW)) u_sram_dual_en (
    .clk(clk), .rst_n(rst_n), .en_low_n(en_low_n), .en_high(en_high),
    .out_req_n(out_req_n), .wr_req_n(wr_req_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .standby(standby)
  );

  function automatic logic [DW-1:0] fill_word(input int a);
    return DW'((a * 37) ^ (a >> 3) ^ 8'h5A);
  endfunction

  function automatic logic is_sel(input logic lo_n, input logic hi);
    return (lo_n == 1'b0) && (hi == 1'b1);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs, lets one rising edge pass,
  // checks at the next falling edge.
  task automatic cyc(input logic lo_n, input logic hi, input logic oq_n, input logic wq_n,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    logic sel, wr, rd, e_dr, e_sb;
    logic [DW-1:0] e_do;
    string t;
    en_low_n = lo_n; en_high = hi; out_req_n = oq_n; wr_req_n = wq_n;
    addr = a; din = d;
    sel  = is_sel(lo_n, hi);
    wr   = sel && !wq_n;
    rd   = sel && wq_n && !oq_n;
    e_dr = rd;
    e_sb = !sel;
    e_do = rd ? ref_mem[a] : '0;
    if (wr) ref_mem[a] = d;
    t = tag;
    if (t == "") t = !sel ? "R2" : wr ? "R3" : rd ? "R5" : "R6";
    @(posedge clk);
    @(negedge clk);
    check(dout_en == e_dr, t, "dout_en", 32'(dout_en), 32'(e_dr));
    check(standby == e_sb, t, "standby", 32'(standby), 32'(e_sb));
    check(dout == e_do, rd ? t : "R7", "dout", 32'(dout), 32'(e_do));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    // R1: reset state, even with a read request pending
    en_low_n = 1'b0; en_high = 1'b1; out_req_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dout_en == 1'b0, "R1", "dout_en", 32'(dout_en), 0);
    check(dout == '0, "R1", "dout", 32'(dout), 0);
    check(standby == 1'b1, "R1", "standby", 32'(standby), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: back-to-back fill of every address, read request alternating (R3)
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b0, 1'b1, 1'(i), 1'b0, AW'(i), fill_word(i), (i < 4) ? "R9" : "");
    for (int i = 0; i < 8; i++)
      cyc(1'b0, 1'b1, 1'b0, 1'b1, AW'(i), '0, "R9");

    // R5: read word written on the preceding edge
    cyc(1'b0, 1'b1, 1'b1, 1'b0, AW'(100), 8'hC3, "R5");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, AW'(100), '0, "R5");

    // R4: write attempts with one enable missing leave the word untouched
    cyc(1'b1, 1'b1, 1'b0, 1'b0, AW'(7), 8'hEE, "R4");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, AW'(7), 8'hEE, "R4");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, AW'(7), 8'hEE, "R4");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, AW'(7), '0, "R4");

    // R6: outputs off while selected
    cyc(1'b0, 1'b1, 1'b1, 1'b1, AW'(7), '0, "R6");

    // R8: long sleep then read back
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, AW'(i), '0, "R8");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, AW'(100), '0, "R8");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, AW'(DEPTH-1), '0, "R8");

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      r = int'($urandom % 8);
      a = AW'($urandom);
      d = DW'($urandom);
      case (r)
        0:       cyc(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), a, d, "");
        1:       cyc(1'($urandom), 1'b0, 1'($urandom), 1'($urandom), a, d, "");
        2, 3, 4: cyc(1'b0, 1'b1, 1'b0, 1'b1, a, d, "");
        5, 6:    cyc(1'b0, 1'b1, 1'($urandom), 1'b0, a, d, "");
        default: cyc(1'b0, 1'b1, 1'b1, 1'b1, a, d, "");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule